// File: doc/BRIEF.md
# Sidetone Filter Coefficient Loader

This block is the register front end of an audio sidetone path. A host on a simple 32-bit register bus programs it. The bus carries an address, a write strobe, a read strobe, write data and read data. The host sets two signed 16-bit channel gains, a clock-idle permission bit, an interrupt mask and a control word. It fills a 128-entry table of signed 16-bit filter taps.

All taps go in through one fixed port address. The host first sets the load-enable bit in the control word. Each following write to the tap port stores the low half-word at the next index, counting up from zero. After the last entry has been written, a read-only completion flag rises. Clearing the load-enable bit ends the load and clears the flag. Setting the bit again restarts the load at index zero.

A downstream filter reads the stored taps through an index/data port and reads the gains through two outputs. The block does not contain the filter arithmetic. It drives a sidetone-active output and a clock-idle permission output. It also drives an interrupt built from masked, sticky event bits.

Top module: `sidetone_regif`

## Requirements
- R1: After reset, the register reads are as follows. Offset 0x00 reads the constant 0x0001_0A03. Offset 0x10 reads 1, with bit 0 as the auto-idle permission. Offsets 0x18, 0x1C, 0x24 and 0x2C read 0. st_active_o and irq_o are 0. idle_ok_o is 1.
- R2: While control bit 1 (load enable, offset 0x2C) is set, each write to offset 0x28 stores bits 15:0 of the write data at the next table index, starting at 0 and counting up. coef_o shows the entry selected by coef_idx_i in the same cycle.
- R3: Control bit 2 (load done, read-only) reads 1 from the cycle after the 128th tap write. It reads 0 before that write.
- R4: A tap write is ignored while load enable is clear. Tap writes after the 128th are also ignored and do not wrap. The stored table stays unchanged in both cases.
- R5: Clearing load enable clears load done. Setting load enable again starts the next load at index 0.
- R6: Offset 0x24 holds the channel 0 gain in bits 15:0 and the channel 1 gain in bits 31:16. Both are signed. gain0_o and gain1_o present the two fields.
- R7: st_active_o is 1 exactly when control bit 0 (sidetone enable) and the port-side input port_en_i are both 1.
- R8: idle_ok_o follows bit 0 of offset 0x10. When the bit is 1, the functional clock may be gated. When it is 0, the clock must keep running.
- R9: Interrupt status at offset 0x18 has two sticky bits. Bit 0 sets when a load completes. Bit 1 sets when a tap write is dropped past the end of the table. Writing a 1 to a bit clears it, and a set event in the same cycle wins. irq_o is 1 when any status bit is set whose mask bit at offset 0x1C is also set.
- R10: Writes to offset 0x00 and to the done bit have no effect. Reads of offset 0x28 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |
| port_en_i | input | 1 | Sidetone enable from the serial-port side |
| coef_idx_i | input | 7 | Tap index for the filter read port |
| coef_o | output | 16 | Stored tap at coef_idx_i |
| gain0_o | output | 16 | Channel 0 gain |
| gain1_o | output | 16 | Channel 1 gain |
| st_active_o | output | 1 | Sidetone path active |
| idle_ok_o | output | 1 | Functional clock may be gated |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench checks the done flag right after the 127th tap write and again right after the 128th. A design with an off-by-one pointer would raise the flag one write early or one write late. After a full load, a 129th write must leave entry 0 unchanged. A design whose pointer wraps would overwrite entry 0. The bench then clears and re-sets load enable and writes a short second load. A design that does not re-arm would put those taps after the old entries instead of at index 0. Write-one-to-clear is checked on one status bit while the other bit stays set. A design that clears on any write, or clears both bits, would fail that check.

// File: rtl/sidetone_pkg.sv
package sidetone_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned SAMP_W  = 16;
  localparam logic [BUS_W-1:0] REV_VALUE = 32'h0001_0A03;

  localparam logic [ADDR_W-1:0] OFS_REV   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ISTAT = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IMASK = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_GAIN  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_TAP   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h2C;

  localparam int unsigned EVT_W = 2;

  // Sticky status update: set events win over write-one-to-clear.
  function automatic logic [EVT_W-1:0] stat_next(input logic [EVT_W-1:0] cur,
                                                 input logic [EVT_W-1:0] clr,
                                                 input logic [EVT_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_masked(input logic [EVT_W-1:0] stat,
                                      input logic [EVT_W-1:0] mask);
    return |(stat & mask);
  endfunction

  function automatic logic [BUS_W-1:0] pack_gains(input logic [SAMP_W-1:0] g0,
                                                  input logic [SAMP_W-1:0] g1);
    return {g1, g0};
  endfunction
endpackage

// File: rtl/st_coef_store.sv
module st_coef_store #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              port_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [PTR_W-1:0]  ptr,
  output logic              load_evt,
  output logic              drop_evt
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

  logic [DATA_W-1:0] table_q [DEPTH];
  logic              accept;

  assign accept   = port_wr && load_en && (ptr < FULL);
  assign load_evt = accept && (ptr == LAST);
  assign drop_evt = port_wr && load_en && (ptr == FULL);
  assign rd_data  = table_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      done <= 1'b0;
    end else if (!load_en) begin
      ptr  <= '0;
      done <= 1'b0;
    end else if (accept) begin
      ptr <= ptr + 1'b1;
      if (load_evt) done <= 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) table_q[i] <= '0;
      else if (accept && (ptr[IDX_W-1:0] == IDX_W'(i))) table_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/st_ctrl_regs.sv
module st_ctrl_regs
  import sidetone_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              load_evt,
  input  logic              drop_evt,
  output logic              cfg_idle,
  output logic [EVT_W-1:0]  irq_stat,
  output logic [EVT_W-1:0]  irq_mask,
  output logic [SAMP_W-1:0] gain0,
  output logic [SAMP_W-1:0] gain1,
  output logic              ctl_en,
  output logic              ctl_wen,
  output logic              irq
);
  logic [EVT_W-1:0] clr_bits;
  logic [EVT_W-1:0] evt_bits;

  assign clr_bits = (wr && addr == OFS_ISTAT) ? wdata[EVT_W-1:0] : '0;
  assign evt_bits = {drop_evt, load_evt};
  assign irq      = any_masked(irq_stat, irq_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_idle <= 1'b1;
      irq_stat <= '0;
      irq_mask <= '0;
      gain0    <= '0;
      gain1    <= '0;
      ctl_en   <= 1'b0;
      ctl_wen  <= 1'b0;
    end else begin
      irq_stat <= stat_next(irq_stat, clr_bits, evt_bits);
      if (wr) begin
        unique case (addr)
          OFS_CFG:   cfg_idle <= wdata[0];
          OFS_IMASK: irq_mask <= wdata[EVT_W-1:0];
          OFS_GAIN: begin
            gain0 <= wdata[SAMP_W-1:0];
            gain1 <= wdata[2*SAMP_W-1:SAMP_W];
          end
          OFS_CTRL: begin
            ctl_en  <= wdata[0];
            ctl_wen <= wdata[1];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sidetone_regif.sv
module sidetone_regif
  import sidetone_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              port_en_i,
  input  logic [IDX_W-1:0]  coef_idx_i,
  output logic [SAMP_W-1:0] coef_o,
  output logic [SAMP_W-1:0] gain0_o,
  output logic [SAMP_W-1:0] gain1_o,
  output logic              st_active_o,
  output logic              idle_ok_o,
  output logic              irq_o
);
  logic             coef_port_wr;
  logic             coef_done;
  logic [PTR_W-1:0] wr_ptr;
  logic             load_evt;
  logic             drop_evt;
  logic             cfg_idle;
  logic [EVT_W-1:0] irq_stat;
  logic [EVT_W-1:0] irq_mask;
  logic             ctrl_en;
  logic             ctrl_wen;

  assign coef_port_wr = bus_wr && (bus_addr == OFS_TAP);

  st_ctrl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .load_evt (load_evt),
    .drop_evt (drop_evt),
    .cfg_idle (cfg_idle),
    .irq_stat (irq_stat),
    .irq_mask (irq_mask),
    .gain0    (gain0_o),
    .gain1    (gain1_o),
    .ctl_en   (ctrl_en),
    .ctl_wen  (ctrl_wen),
    .irq      (irq_o)
  );

  st_coef_store #(.DEPTH(DEPTH), .DATA_W(SAMP_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (ctrl_wen),
    .port_wr  (coef_port_wr),
    .wdata    (bus_wdata[SAMP_W-1:0]),
    .rd_idx   (coef_idx_i),
    .rd_data  (coef_o),
    .done     (coef_done),
    .ptr      (wr_ptr),
    .load_evt (load_evt),
    .drop_evt (drop_evt)
  );

  assign st_active_o = ctrl_en && port_en_i;
  assign idle_ok_o   = cfg_idle;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_REV:   bus_rdata = REV_VALUE;
        OFS_CFG:   bus_rdata = BUS_W'(cfg_idle);
        OFS_ISTAT: bus_rdata = BUS_W'(irq_stat);
        OFS_IMASK: bus_rdata = BUS_W'(irq_mask);
        OFS_GAIN:  bus_rdata = pack_gains(gain0_o, gain1_o);
        OFS_CTRL:  bus_rdata = BUS_W'({coef_done, ctrl_wen, ctrl_en});
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/st_regif_chk.sv
module st_regif_chk #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned PTR_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             port_wr,
  input logic             coef_wen,
  input logic             done,
  input logic [PTR_W-1:0] wr_ptr,
  input logic             load_evt,
  input logic             drop_evt,
  input logic [1:0]       irq_stat,
  input logic             port_en_i,
  input logic             st_active_o
);
  p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= PTR_W'(DEPTH));

  p_off_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !coef_wen |=> (wr_ptr == '0));

  p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(load_evt));

  p_done_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !coef_wen |=> !done);

  p_load_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> irq_stat[0]);

  p_drop_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> irq_stat[1]);

  p_drop_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && coef_wen && done) |=> $stable(wr_ptr));

  p_port_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en_i |-> !st_active_o);
endmodule

bind sidetone_regif st_regif_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_wr     (coef_port_wr),
  .coef_wen    (ctrl_wen),
  .done        (coef_done),
  .wr_ptr      (wr_ptr),
  .load_evt    (load_evt),
  .drop_evt    (drop_evt),
  .irq_stat    (irq_stat),
  .port_en_i   (port_en_i),
  .st_active_o (st_active_o)
);

// File: tb/sidetone_regif_tb.sv
module sidetone_regif_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        port_en_i = 1'b0;
  logic [6:0]  coef_idx_i = '0;
  logic [15:0] coef_o, gain0_o, gain1_o;
  logic        st_active_o, idle_ok_o, irq_o;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  bit          finished = 1'b0;
  logic [15:0] model [128];

  sidetone_regif u_dut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] exp_gain(input logic [15:0] g0, input logic [15:0] g1);
    return (32'(g1) << 16) | 32'(g0);
  endfunction

  function automatic logic exp_irq(input logic [1:0] st, input logic [1:0] mk);
    return (st[0] & mk[0]) | (st[1] & mk[1]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic tap(input logic [15:0] i, output logic [15:0] d);
    @(negedge clk);
    coef_idx_i = i[6:0];
    #1 d = coef_o;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] t, g0, g1;
    logic [15:0] keep0;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd17);
    for (int i = 0; i < 128; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d); chk("R1 rev", d, 32'h0001_0A03);
    rd(8'h10, d); chk("R1 cfg", d, 32'd1);
    rd(8'h18, d); chk("R1 istat", d, 0);
    rd(8'h24, d); chk("R1 gain", d, 0);
    rd(8'h2C, d); chk("R1 ctrl", d, 0);
    chk("R1 outs", {st_active_o, idle_ok_o, irq_o}, 3'b010);

    // R4 tap write while load enable clear is ignored
    wr(8'h28, 32'h0000_1234);
    tap(0, t); chk("R4 off write", t, 16'h0000);

    // R2/R3 full load with random upper bits
    wr(8'h2C, 32'h2);
    for (int i = 0; i < 127; i++) begin
      d = $urandom;
      model[i] = d[15:0];
      wr(8'h28, d);
    end
    rd(8'h2C, d); chk("R3 not done at 127", d[2], 0);
    rd(8'h18, d); chk("R9 no load evt yet", d, 0);
    d = $urandom; model[127] = d[15:0];
    wr(8'h28, d);
    rd(8'h2C, d); chk("R3 done at 128", d[2], 1);
    rd(8'h18, d); chk("R9 load evt", d, 32'd1);
    for (int k = 0; k < 8; k++) begin
      int unsigned ix;
      ix = $urandom_range(127);
      tap(16'(ix), t); chk("R2 tap", t, model[ix]);
    end
    tap(0, t); chk("R2 first", t, model[0]);
    tap(127, t); chk("R2 last", t, model[127]);

    // R4 write past end: no wrap, drop event
    keep0 = model[0];
    wr(8'h28, {16'h0, ~keep0});
    tap(0, t); chk("R4 no wrap", t, keep0);
    tap(127, t); chk("R4 last kept", t, model[127]);
    rd(8'h18, d); chk("R9 drop evt", d, 32'd3);

    // R9 W1C and mask
    chk("R9 irq masked", irq_o, exp_irq(2'b11, 2'b00));
    wr(8'h1C, 32'h2);
    chk("R9 irq on", irq_o, exp_irq(2'b11, 2'b10));
    wr(8'h18, 32'h1);
    rd(8'h18, d); chk("R9 w1c one bit", d, 32'd2);
    wr(8'h18, 32'h2);
    rd(8'h18, d); chk("R9 w1c other", d, 0);
    chk("R9 irq off", irq_o, exp_irq(2'b00, 2'b10));

    // R10 read-only / unmapped
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R10 rev ro", d, 32'h0001_0A03);
    wr(8'h2C, 32'h6);
    rd(8'h2C, d); chk("R10 done ro", d, 32'h6);
    rd(8'h28, d); chk("R10 tap reads 0", d, 0);
    rd(8'h40, d); chk("R10 unmapped", d, 0);

    // R5 clear re-arms at index 0
    wr(8'h2C, 32'h0);
    rd(8'h2C, d); chk("R5 done cleared", d, 0);
    wr(8'h2C, 32'h2);
    for (int i = 0; i < 3; i++) begin
      d = $urandom; model[i] = d[15:0];
      wr(8'h28, d);
    end
    for (int i = 0; i < 4; i++) begin
      tap(16'(i), t); chk("R5 reload", t, model[i]);
    end
    rd(8'h2C, d); chk("R5 not done", d[2], 0);

    // R6 gains
    for (int k = 0; k < 6; k++) begin
      g0 = $urandom; g1 = $urandom;
      if (k == 0) begin g0 = 16'h8000; g1 = 16'h7FFF; end
      wr(8'h24, {g1, g0});
      rd(8'h24, d); chk("R6 gain reg", d, exp_gain(g0, g1));
      chk("R6 gain0", gain0_o, g0);
      chk("R6 gain1", gain1_o, g1);
    end

    // R7 active combos
    for (int c = 0; c < 4; c++) begin
      wr(8'h2C, {30'h0, 1'b1, c[0]});
      port_en_i = c[1];
      #1 chk("R7 active", st_active_o, c[0] & c[1]);
    end

    // R8 idle
    wr(8'h10, 32'h0); chk("R8 idle off", idle_ok_o, 0);
    wr(8'h10, 32'h1); chk("R8 idle on", idle_ok_o, 1);

    finished = 1'b1;
    summary();
  end
endmodule